// File: doc/BRIEF.md
# PLL Reference and Feedback Divider Chain

This block holds the two digital frequency dividers that feed a phase-frequency detector. The reference path counts events of a reference clock and divides them by 13, 26, 39 or 52, as selected by a two-bit control field. The feedback path takes events of the oscillator clock and halves them in a fixed prescaler. The prescaler output then drives a programmable counter with a 9-bit ratio N. Each path emits a single-cycle pulse at its terminal count, and the phase detector compares these pulses.

Both input clocks arrive as clock-enable strobes (`ref_ce`, `vco_ce`) in the single system clock domain. One input event is one system cycle with the strobe high. A loop enable holds both paths cleared and silent while it is low. A new ratio on either path is picked up only at that path's terminal count, so no period is ever cut short. The active reference ratio comes out of reset at 13.

Top module: `pll_div_chain`

## Requirements
- R1: With `ref_sel` = 0, 1, 2, 3 the reference ratio R is 13, 26, 39, 52. `ref_pulse` is high for the one cycle after every R-th `ref_ce` event counted since enable or since the previous terminal count.
- R2: After `rst`, the active reference ratio is 13 whatever `ref_sel` holds. It stays 13 until the first reference terminal count.
- R3: A change of `ref_sel` leaves the period in progress at its old ratio. The new ratio applies from the period that starts after the next reference pulse.
- R4: `main_pulse` is high for the one cycle after every 2*N-th `vco_ce` event, because a fixed divide-by-two stage precedes the N counter.
- R5: A `main_n` value below N_MIN (default 2) acts as N_MIN, so `main_n` = 0 or 1 gives one pulse per 4 `vco_ce` events.
- R6: A change of `main_n` leaves the period in progress at its old ratio. The new ratio applies from the period that starts after the next feedback pulse.
- R7: While `pll_en` is low, both pulses are low from the next cycle on and all counters, including the prescaler phase, stay cleared. When `pll_en` rises, counting restarts from zero with the ratios present on `ref_sel` and `main_n` while the enable was low.
- R8: Each pulse is exactly one cycle wide. It occurs only in the cycle after one in which its strobe and `pll_en` were both high.
- R9: `rst` is synchronous and active high. Both pulses are low in the cycle after a cycle with `rst` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_en | input | 1 | Loop enable; low holds both dividers cleared |
| ref_ce | input | 1 | One reference clock event per high cycle |
| vco_ce | input | 1 | One oscillator clock event per high cycle |
| ref_sel | input | SEL_W (2) | Reference ratio select: 13*(ref_sel+1) |
| main_n | input | N_W (9) | Feedback counter ratio N |
| ref_pulse | output | 1 | Reference terminal-count pulse |
| main_pulse | output | 1 | Feedback terminal-count pulse |

## Verification
Every reference select is run with strobes on every cycle, on every third cycle and in a pseudo-random pattern. Counting pulses against strobe events separates the ratio itself from any dependence on strobe spacing. N is swept from 0 through 24, with 100 and 511 added, so the clamp floor, the factor of two from the prescaler and the full counter width each show up in the pulse count. Ratio changes made mid-period, a reset taken while a large select is present, and a drop of the enable mid-period are each tracked against the position of the first pulse. That position tells a deferred ratio load apart from an immediate one, and a true restart apart from a resumed count.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

    // Control handed from the top to each counting stage.
    typedef struct packed {
        logic hold;   // loop disabled: clear and reload
        logic step;   // one input event this cycle
    } div_ctl_t;

    // Reference ratio for a select code: base times (code + 1).
    function automatic int unsigned ref_ratio(input int unsigned sel,
                                              input int unsigned base);
        return base * (sel + 1);
    endfunction

    // Raise a requested ratio to the legal floor.
    function automatic int unsigned clamp_ratio(input int unsigned n,
                                                input int unsigned floor_v);
        return (n < floor_v) ? floor_v : n;
    endfunction

endpackage

// File: rtl/pd_ref_divider.sv
module pd_ref_divider
    import pll_div_pkg::*;
#(
    parameter int unsigned BASE  = 13,
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  div_ctl_t         ctl,
    input  logic [SEL_W-1:0] sel_in,
    output logic             pulse_o
);
    localparam int unsigned MAX_R = BASE * (2 ** SEL_W);
    localparam int unsigned CNT_W = $clog2(MAX_R + 1);

    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_c;
    logic             term_c;

    always_comb begin
        last_c = CNT_W'(ref_ratio(int'(sel_q), BASE) - 1);
        term_c = ctl.step && (cnt_q == last_c);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            cnt_q   <= '0;
            pulse_o <= 1'b0;
        end else if (ctl.hold) begin
            sel_q   <= sel_in;
            cnt_q   <= '0;
            pulse_o <= 1'b0;
        end else if (term_c) begin
            sel_q   <= sel_in;
            cnt_q   <= '0;
            pulse_o <= 1'b1;
        end else begin
            if (ctl.step) begin
                cnt_q <= cnt_q + 1'b1;
            end
            pulse_o <= 1'b0;
        end
    end
endmodule

// File: rtl/pd_prescaler.sv
module pd_prescaler (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic ce,
    output logic tick_o
);
    logic phase_q;

    // Every second input event passes on.
    always_comb tick_o = ce && phase_q && !hold;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            phase_q <= 1'b0;
        end else if (ce) begin
            phase_q <= !phase_q;
        end
    end
endmodule

// File: rtl/pd_main_counter.sv
module pd_main_counter
    import pll_div_pkg::*;
#(
    parameter int unsigned N_W   = 9,
    parameter int unsigned N_MIN = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  div_ctl_t       ctl,
    input  logic [N_W-1:0] n_in,
    output logic           pulse_o
);
    localparam int unsigned FLOOR = (N_MIN < 1) ? 1 : N_MIN;

    logic [N_W-1:0] n_q;
    logic [N_W-1:0] cnt_q;
    logic [N_W-1:0] n_next;
    logic           term_c;

    always_comb begin
        n_next = N_W'(clamp_ratio(int'(n_in), FLOOR));
        term_c = ctl.step && (cnt_q == n_q - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.hold) begin
            n_q     <= n_next;
            cnt_q   <= '0;
            pulse_o <= 1'b0;
        end else if (term_c) begin
            n_q     <= n_next;
            cnt_q   <= '0;
            pulse_o <= 1'b1;
        end else begin
            if (ctl.step) begin
                cnt_q <= cnt_q + 1'b1;
            end
            pulse_o <= 1'b0;
        end
    end
endmodule

// File: rtl/pll_div_chain.sv
module pll_div_chain
    import pll_div_pkg::*;
#(
    parameter int unsigned REF_BASE = 13,
    parameter int unsigned SEL_W    = 2,
    parameter int unsigned N_W      = 9,
    parameter int unsigned N_MIN    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pll_en,
    input  logic             ref_ce,
    input  logic             vco_ce,
    input  logic [SEL_W-1:0] ref_sel,
    input  logic [N_W-1:0]   main_n,
    output logic             ref_pulse,
    output logic             main_pulse
);
    div_ctl_t ref_ctl;
    div_ctl_t main_ctl;
    logic     half_tick;

    always_comb begin
        ref_ctl.hold  = !pll_en;
        ref_ctl.step  = ref_ce;
        main_ctl.hold = !pll_en;
        main_ctl.step = half_tick;
    end

    pd_ref_divider #(.BASE(REF_BASE), .SEL_W(SEL_W)) ref_div_i (
        .clk(clk), .rst(rst), .ctl(ref_ctl), .sel_in(ref_sel), .pulse_o(ref_pulse)
    );

    pd_prescaler pre_i (
        .clk(clk), .rst(rst), .hold(!pll_en), .ce(vco_ce), .tick_o(half_tick)
    );

    pd_main_counter #(.N_W(N_W), .N_MIN(N_MIN)) main_div_i (
        .clk(clk), .rst(rst), .ctl(main_ctl), .n_in(main_n), .pulse_o(main_pulse)
    );
endmodule

// File: rtl/pll_div_chain_chk.sv
module pll_div_chain_chk #(
    parameter int unsigned REF_BASE = 13,
    parameter int unsigned SEL_W    = 2,
    parameter int unsigned N_MIN    = 2
) (
    input logic clk,
    input logic rst,
    input logic pll_en,
    input logic ref_ce,
    input logic vco_ce,
    input logic ref_pulse,
    input logic main_pulse
);
    localparam int unsigned MAIN_FLOOR = (N_MIN < 1) ? 2 : 2 * N_MIN;

    // Strobe events seen since the last pulse on each path.
    logic [15:0] rc_q;
    logic [15:0] mc_q;

    always_ff @(posedge clk) begin
        if (rst || !pll_en) begin
            rc_q <= '0;
            mc_q <= '0;
        end else begin
            rc_q <= (ref_pulse  ? 16'd0 : rc_q) + {15'd0, ref_ce};
            mc_q <= (main_pulse ? 16'd0 : mc_q) + {15'd0, vco_ce};
        end
    end

    p_ref_multiple_r1: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |-> (rc_q % 16'(REF_BASE) == 16'd0) && (rc_q >= 16'(REF_BASE))
                      && (rc_q <= 16'(REF_BASE * (2 ** SEL_W))));

    p_main_even_r4: assert property (@(posedge clk) disable iff (rst)
        main_pulse |-> (mc_q[0] == 1'b0));

    p_main_floor_r5: assert property (@(posedge clk) disable iff (rst)
        main_pulse |-> (mc_q >= 16'(MAIN_FLOOR)));

    p_off_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !pll_en |=> (!ref_pulse && !main_pulse));

    p_ref_single_r8: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |=> !ref_pulse);

    p_main_single_r8: assert property (@(posedge clk) disable iff (rst)
        main_pulse |=> !main_pulse);

    p_ref_cause_r8: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |-> $past(ref_ce && pll_en));

    p_main_cause_r8: assert property (@(posedge clk) disable iff (rst)
        main_pulse |-> $past(vco_ce && pll_en));

    p_rst_clear_r9: assert property (@(posedge clk)
        rst |=> (!ref_pulse && !main_pulse));
endmodule

bind pll_div_chain pll_div_chain_chk #(
    .REF_BASE(REF_BASE), .SEL_W(SEL_W), .N_MIN(N_MIN)
) chk_i (
    .clk(clk), .rst(rst), .pll_en(pll_en), .ref_ce(ref_ce), .vco_ce(vco_ce),
    .ref_pulse(ref_pulse), .main_pulse(main_pulse)
);

// File: tb/pll_div_chain_tb_top.sv
`timescale 1ns/1ps
module pll_div_chain_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pll_en = 1'b0;
    logic       ref_ce = 1'b0;
    logic       vco_ce = 1'b0;
    logic [1:0] ref_sel = 2'd0;
    logic [8:0] main_n = 9'd2;
    logic       ref_pulse;
    logic       main_pulse;

    always #2.5 clk = ~clk;

    pll_div_chain dut_i (
        .clk(clk), .rst(rst), .pll_en(pll_en), .ref_ce(ref_ce), .vco_ce(vco_ce),
        .ref_sel(ref_sel), .main_n(main_n), .ref_pulse(ref_pulse), .main_pulse(main_pulse)
    );

    int    n_vec  = 0;
    int    n_bad  = 0;
    int    cyc    = 0;
    int    ref_gap  = 1;
    int    vco_gap  = 1;
    logic [15:0] lfsr = 16'hACE1;
    string cur_req = "R9";
    bit    done = 0;

    // Bench model state, built from the requirements.
    int m_rsel, m_rcnt, m_mcnt, m_n;
    bit m_pre;
    bit exp_ref = 0, exp_main = 0;
    int ce_ref, ce_vco, seen_ref, seen_main;

    function automatic int clampn(input int n);
        return (n < 2) ? 2 : n;
    endfunction

    function automatic logic gen(input int gap, input int bitsel);
        if (gap < 0) return 1'b0;
        if (gap == 0) return lfsr[bitsel];
        return (cyc % gap) == 0;
    endfunction

    task automatic model();
        if (rst) begin
            m_rsel = 0; m_rcnt = 0; m_mcnt = 0; m_pre = 0;
            m_n = clampn(int'(main_n)); exp_ref = 0; exp_main = 0;
        end else if (!pll_en) begin
            m_rsel = int'(ref_sel); m_rcnt = 0; m_mcnt = 0; m_pre = 0;
            m_n = clampn(int'(main_n)); exp_ref = 0; exp_main = 0;
        end else begin
            exp_ref = 0;
            exp_main = 0;
            if (ref_ce) begin
                ce_ref++;
                m_rcnt++;
                if (m_rcnt == 13 * (m_rsel + 1)) begin
                    exp_ref = 1; m_rcnt = 0; m_rsel = int'(ref_sel);
                end
            end
            if (vco_ce) begin
                ce_vco++;
                if (m_pre) begin
                    m_mcnt++;
                    if (m_mcnt == m_n) begin
                        exp_main = 1; m_mcnt = 0; m_n = clampn(int'(main_n));
                    end
                end
                m_pre = !m_pre;
            end
        end
    endtask

    task automatic step();
        model();
        @(negedge clk);
        n_vec++;
        if (ref_pulse !== exp_ref || main_pulse !== exp_main) begin
            n_bad++;
            $display("FAIL %s: cycle %0d pulses ref=%b main=%b expected ref=%b main=%b",
                     cur_req, cyc, ref_pulse, main_pulse, exp_ref, exp_main);
        end
        if (ref_pulse === 1'b1) seen_ref++;
        if (main_pulse === 1'b1) seen_main++;
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ref_ce = gen(ref_gap, 3);
        vco_ce = gen(vco_gap, 7);
    endtask

    task automatic check(input string req, input int act, input int expv);
        n_vec++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic restart();
        pll_en = 1'b0;
        step();
        step();
        ce_ref = 0; ce_vco = 0; seen_ref = 0; seen_main = 0;
        pll_en = 1'b1;
    endtask

    task automatic drain();
        ref_gap = -1; vco_gap = -1;
        repeat (3) step();
    endtask

    initial begin
        int first;
        // R9: reset state
        cur_req = "R9";
        repeat (3) step();
        rst = 1'b0;
        step();
        check("R9 ref_pulse after reset", int'(ref_pulse), 0);
        check("R9 main_pulse after reset", int'(main_pulse), 0);

        // R2: reset default ratio 13 with select 3 present
        cur_req = "R2";
        ref_gap = 1; vco_gap = -1; ref_sel = 2'd3; pll_en = 1'b1;
        rst = 1'b1; step(); step(); rst = 1'b0;
        first = 0;
        for (int i = 1; i <= 13 + 52 + 2; i++) begin
            step();
            if (ref_pulse && first == 0) first = i;
        end
        check("R2 first reference pulse position", first, 13);

        // R1: every select under several strobe patterns
        cur_req = "R1";
        for (int s = 0; s < 4; s++) begin
            for (int g = 0; g < 3; g++) begin
                ref_sel = 2'(s);
                ref_gap = (g == 2) ? 0 : ((g == 1) ? 3 : 1);
                vco_gap = -1;
                restart();
                repeat (13 * (s + 1) * 8) step();
                drain();
                check($sformatf("R1 sel=%0d gap=%0d pulses", s, g), seen_ref, ce_ref / (13 * (s + 1)));
                check($sformatf("R1 sel=%0d gap=%0d nonzero", s, g), int'(seen_ref > 1), 1);
            end
        end

        // R3: select change mid-period
        cur_req = "R3";
        ref_sel = 2'd0; ref_gap = 1; vco_gap = -1;
        restart();
        repeat (5) step();
        ref_sel = 2'd2;
        for (int i = 6; i <= 13 + 39; i++) step();
        check("R3 pulses after 13+39 events", seen_ref, 2);

        // R4: N sweep with several patterns
        cur_req = "R4";
        for (int n = 2; n <= 26; n++) begin
            main_n = (n == 25) ? 9'd100 : ((n == 26) ? 9'd511 : 9'(n));
            ref_gap = -1;
            vco_gap = n % 3;
            restart();
            repeat (clampn(int'(main_n)) * 2 * 4 * ((vco_gap == 1) ? 1 : 3)) step();
            drain();
            check($sformatf("R4 N=%0d pulses", main_n), seen_main, ce_vco / (2 * clampn(int'(main_n))));
        end

        // R5: values below the floor
        cur_req = "R5";
        for (int n = 0; n < 2; n++) begin
            main_n = 9'(n); vco_gap = 1; ref_gap = -1;
            restart();
            repeat (40) step();
            drain();
            check($sformatf("R5 N=%0d pulses per 4 events", n), seen_main, ce_vco / 4);
        end

        // R6: N change mid-period
        cur_req = "R6";
        main_n = 9'd5; vco_gap = 1; ref_gap = -1;
        restart();
        repeat (3) step();
        main_n = 9'd9;
        for (int i = 4; i <= 28; i++) step();
        check("R6 pulses after 10+18 events", seen_main, 2);

        // R7: enable dropped mid-period, restart with new select
        cur_req = "R7";
        ref_sel = 2'd0; main_n = 9'd4; ref_gap = 1; vco_gap = 1;
        restart();
        repeat (9) step();
        pll_en = 1'b0;
        ref_sel = 2'd1;
        first = 0;
        for (int i = 0; i < 5; i++) begin
            step();
            if (i > 0) first += int'(ref_pulse) + int'(main_pulse);
        end
        check("R7 pulses while disabled", first, 0);
        pll_en = 1'b1;
        first = 0;
        for (int i = 1; i <= 30; i++) begin
            step();
            if (ref_pulse && first == 0) first = i;
        end
        check("R7 first reference pulse after re-enable", first, 26);

        // R8: random strobes on both paths
        cur_req = "R8";
        ref_sel = 2'd3; main_n = 9'd3; ref_gap = 0; vco_gap = 0;
        restart();
        repeat (2000) step();
        drain();
        check("R8 reference pulse count", seen_ref, ce_ref / 52);
        check("R8 feedback pulse count", seen_main, ce_vco / 6);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule